// File: doc/BRIEF.md
# CAN Receive Identifier Filter

This block decides which receive message buffer takes an incoming CAN frame. The frame's identifier arrives as two 16-bit words: a base word and an extension word. Every buffer holds the same pair of words, together with its 4-bit status code. The filter compares the frame against every buffer whose status allows reception. A mask bit set to 1 removes that bit from the comparison.

All buffers except the last share one global mask pair. The last buffer has its own basic mask pair. Setting that pair to all ones turns the last buffer into a catch-all. One cycle after a frame is presented, the block gives one of two results:

- a single-cycle hit pulse with the index of the winning buffer, or
- a single-cycle miss pulse.

Bit-level reception and the buffer status machine are outside this block. The buffer contents and status codes reach it as flat vectors, with buffer i in slice i.

Top module: `can_id_filter`

## Requirements
- R1: In the base word, bits 15:5 hold the 11-bit standard identifier (ID[28:18] of an extended one), bit 4 holds RTR (SRR for extended frames), bit 3 holds IDE and bits 2:0 hold ID[17:15]. For a frame with IDE=0, only base bits 15:3 are compared. Base bits 2:0 and the whole extension word are ignored.
- R2: In the extension word, bits 15:1 hold ID[14:0] and bit 0 holds XRTR. For a frame with IDE=1, all 16 bits of both words are compared. A frame whose IDE bit differs from the buffer's IDE bit does not match unless mask bit 3 is set.
- R3: A compared bit counts only where its mask bit is 0. An all-zero mask demands an exact match, and a mask bit of 1 makes that identifier bit a don't-care.
- R4: Buffers 0 to NBUF-2 use the global mask pair. Buffer NBUF-1 uses the basic mask pair. With an all-ones basic mask, the last buffer matches any frame, and the global mask never affects it.
- R5: A buffer takes part only when its status code is 4'b0010 (receive ready) or 4'b0100 (receive full). Any other code excludes it.
- R6: When several buffers match, the lowest index wins. The last buffer is chosen only if no other buffer matches.
- R7: One cycle after a clock edge that samples frm_valid_i high, exactly one of hit_o and miss_o is high, for that one cycle. hit_idx_o carries the winner while hit_o is high and is 0 otherwise.
- R8: During and immediately after reset, hit_o, miss_o and hit_idx_o are 0.
- R9: With mask bits base[4] and ext[0] set, a data frame (RTR/XRTR=0) is accepted by a buffer configured with the remote-request bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid_i | input | 1 | Frame identifier present this cycle |
| frm_base_i | input | 16 | Frame base identifier word |
| frm_ext_i | input | 16 | Frame extension identifier word |
| buf_base_i | input | 16*NBUF | Base words of all buffers, buffer i at [16i+15:16i] |
| buf_ext_i | input | 16*NBUF | Extension words of all buffers |
| buf_state_i | input | 4*NBUF | Status codes of all buffers |
| gmask_base_i | input | 16 | Global mask, base word |
| gmask_ext_i | input | 16 | Global mask, extension word |
| bmask_base_i | input | 16 | Basic mask for the last buffer, base word |
| bmask_ext_i | input | 16 | Basic mask for the last buffer, extension word |
| hit_o | output | 1 | One-cycle accept pulse |
| miss_o | output | 1 | One-cycle no-match pulse |
| hit_idx_o | output | $clog2(NBUF) | Index of the accepting buffer |

## Verification
The interesting collisions come from overlapping matches, in two forms:

- A regular buffer and the catch-all buffer match the same frame.
- Two regular buffers match the same frame, one of them through a masked bit.

The bench provokes both on purpose by giving several buffers the same identifier, by opening the global or basic mask, and by toggling status codes between eligible and ineligible values. It then runs a long sweep over a small identifier space, so that multiple matches become frequent. Each result is compared with a bench model that decodes the fields one by one and applies the priority order.

// File: rtl/can_id_filter.sv
module can_id_filter #(
  parameter int NBUF = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frm_valid_i,
  input  logic [15:0]             frm_base_i,
  input  logic [15:0]             frm_ext_i,
  input  logic [16*NBUF-1:0]      buf_base_i,
  input  logic [16*NBUF-1:0]      buf_ext_i,
  input  logic [4*NBUF-1:0]       buf_state_i,
  input  logic [15:0]             gmask_base_i,
  input  logic [15:0]             gmask_ext_i,
  input  logic [15:0]             bmask_base_i,
  input  logic [15:0]             bmask_ext_i,
  output logic                    hit_o,
  output logic                    miss_o,
  output logic [$clog2(NBUF)-1:0] hit_idx_o
);
  localparam int IW = $clog2(NBUF);
  localparam logic [3:0] ST_READY = 4'b0010;
  localparam logic [3:0] ST_FULL  = 4'b0100;

  wire frm_is_ext = frm_base_i[3];
  logic [NBUF-1:0] match;

  for (genvar g = 0; g < NBUF; g++) begin : g_cmp
    wire [15:0] mb = (g == NBUF-1) ? bmask_base_i : gmask_base_i;
    wire [15:0] me = (g == NBUF-1) ? bmask_ext_i  : gmask_ext_i;
    wire [3:0]  st = buf_state_i[4*g +: 4];
    wire [15:0] db = (frm_base_i ^ buf_base_i[16*g +: 16]) & ~mb;
    wire [15:0] de = (frm_ext_i  ^ buf_ext_i[16*g +: 16])  & ~me;
    wire        ok = (st == ST_READY) || (st == ST_FULL);
    assign match[g] = ok && (db[15:3] == '0) &&
                      (!frm_is_ext || ((db[2:0] == '0) && (de == '0)));
  end

  logic          found;
  logic [IW-1:0] sel;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = NBUF-2; i >= 0; i--) begin
      if (match[i]) begin
        found = 1'b1;
        sel   = IW'(i);
      end
    end
    if (!found && match[NBUF-1]) begin
      found = 1'b1;
      sel   = IW'(NBUF-1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_o     <= 1'b0;
      miss_o    <= 1'b0;
      hit_idx_o <= '0;
    end else begin
      hit_o     <= frm_valid_i && found;
      miss_o    <= frm_valid_i && !found;
      hit_idx_o <= (frm_valid_i && found) ? sel : '0;
    end
  end
endmodule

module can_id_filter_chk #(
  parameter int NBUF = 15
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    frm_valid_i,
  input logic                    hit_o,
  input logic                    miss_o,
  input logic [$clog2(NBUF)-1:0] hit_idx_o
);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_o && miss_o));
  a_r7_answer: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid_i |=> (hit_o || miss_o));
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid_i |=> !(hit_o || miss_o));
  a_r7_idx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (hit_idx_o == '0));
  a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (int'(hit_idx_o) < NBUF));
endmodule

bind can_id_filter can_id_filter_chk #(.NBUF(NBUF)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid_i(frm_valid_i),
  .hit_o(hit_o), .miss_o(miss_o), .hit_idx_o(hit_idx_o)
);

// File: tb/can_id_filter_bench.sv
module can_id_filter_bench;
  localparam int N = 15;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              frm_valid;
  logic [15:0]       frm_base, frm_ext;
  logic [15:0]       bb [N];
  logic [15:0]       be [N];
  logic [3:0]        bs [N];
  logic [16*N-1:0]   bbv, bev;
  logic [4*N-1:0]    bsv;
  logic [15:0]       gmb, gme, bmb, bme;
  logic              hit, miss;
  logic [3:0]        idx;
  int tests = 0, fails = 0;

  always_comb
    for (int i = 0; i < N; i++) begin
      bbv[16*i +: 16] = bb[i];
      bev[16*i +: 16] = be[i];
      bsv[4*i +: 4]   = bs[i];
    end

  can_id_filter #(.NBUF(N)) u_can_id_filter (
    .clk(clk), .rst_n(rst_n), .frm_valid_i(frm_valid),
    .frm_base_i(frm_base), .frm_ext_i(frm_ext),
    .buf_base_i(bbv), .buf_ext_i(bev), .buf_state_i(bsv),
    .gmask_base_i(gmb), .gmask_ext_i(gme),
    .bmask_base_i(bmb), .bmask_ext_i(bme),
    .hit_o(hit), .miss_o(miss), .hit_idx_o(idx)
  );

  function automatic logic [15:0] sb(input logic [10:0] id, input logic rtr);
    return {id, rtr, 1'b0, 3'b000};
  endfunction
  function automatic logic [15:0] xb(input logic [28:0] id);
    return {id[28:18], 1'b1, 1'b1, id[17:15]};
  endfunction
  function automatic logic [15:0] xe(input logic [28:0] id, input logic xrtr);
    return {id[14:0], xrtr};
  endfunction

  function automatic bit fld_eq(input logic [15:0] a, input logic [15:0] b,
                                input logic [15:0] m, input int hi, input int lo);
    for (int k = lo; k <= hi; k++)
      if (!m[k] && (a[k] !== b[k])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int model(input logic [15:0] fb, input logic [15:0] fe);
    int win = -1;
    for (int i = N-1; i >= 0; i--) begin
      logic [15:0] mb = (i == N-1) ? bmb : gmb;
      logic [15:0] me = (i == N-1) ? bme : gme;
      bit ok = (bs[i] == 4'd2) || (bs[i] == 4'd4);
      bit m  = fld_eq(fb, bb[i], mb, 15, 5) && fld_eq(fb, bb[i], mb, 4, 4) &&
               fld_eq(fb, bb[i], mb, 3, 3);
      if (fb[3]) m = m && fld_eq(fb, bb[i], mb, 2, 0) && fld_eq(fe, be[i], me, 15, 0);
      if (ok && m && (i < N-1 || win < 0)) win = i;
    end
    return win;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic send(input logic [15:0] fb, input logic [15:0] fe,
                      input string req, input int want);
    int exp = model(fb, fe);
    int got;
    @(negedge clk);
    frm_base = fb; frm_ext = fe; frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
    got = hit ? int'(idx) : (miss ? -1 : -2);
    if (hit && miss) got = -3;
    chk(req, got, want);
    chk({req, " model"}, exp, want);
    @(negedge clk);
    chk("R7 pulse width", int'(hit) + int'(miss), 0);
  endtask

  task automatic sweep_one();
    logic [15:0] fb, fe;
    int exp, got;
    for (int i = 0; i < N; i++) begin
      bb[i] = {8'($urandom_range(0, 3)), 3'b0, 1'($urandom), 1'($urandom), 3'($urandom_range(0, 1))};
      be[i] = 16'($urandom_range(0, 3));
      bs[i] = ($urandom_range(0, 3) == 0) ? 4'd8 : (($urandom & 1) ? 4'd2 : 4'd4);
    end
    gmb = ($urandom_range(0, 3) == 0) ? 16'h0020 : 16'h0;
    gme = ($urandom_range(0, 3) == 0) ? 16'h0001 : 16'h0;
    bmb = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'h0;
    bme = bmb;
    fb = {8'($urandom_range(0, 3)), 3'b0, 1'($urandom), 1'($urandom), 3'($urandom_range(0, 1))};
    fe = 16'($urandom_range(0, 3));
    exp = model(fb, fe);
    @(negedge clk);
    frm_base = fb; frm_ext = fe; frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
    got = hit ? int'(idx) : (miss ? -1 : -2);
    chk("R6 sweep", got, exp);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    frm_valid = 0; frm_base = 0; frm_ext = 0;
    gmb = 0; gme = 0; bmb = 0; bme = 0;
    for (int i = 0; i < N; i++) begin bb[i] = 0; be[i] = 0; bs[i] = 4'd0; end
    repeat (3) @(negedge clk);
    chk("R8 reset hit", int'(hit), 0);
    chk("R8 reset miss", int'(miss), 0);
    chk("R8 reset idx", int'(idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 after reset", int'(hit) + int'(miss) + int'(idx), 0);

    send(sb(11'h000, 0), 0, "R5 inactive buffers", -1);
    bb[3] = sb(11'h123, 0); bs[3] = 4'd2;
    send(sb(11'h123, 0), 0, "R1 std exact", 3);
    send(sb(11'h124, 0), 0, "R3 exact mismatch", -1);
    send({11'h123, 1'b0, 1'b0, 3'b101}, 16'hFFFF, "R1 std ignores low/ext", 3);
    gmb = 16'h0020;
    send(sb(11'h122, 0), 0, "R3 masked bit", 3);
    gmb = 16'h0;
    bb[5] = sb(11'h123, 0); bs[5] = 4'd2;
    send(sb(11'h123, 0), 0, "R6 lowest wins", 3);
    bs[3] = 4'd8;
    send(sb(11'h123, 0), 0, "R5 tx state excluded", 5);
    bs[5] = 4'd4;
    send(sb(11'h123, 0), 0, "R5 full eligible", 5);
    bs[5] = 4'd6;
    send(sb(11'h123, 0), 0, "R5 overrun excluded", -1);
    bs[5] = 4'd4;

    bb[7] = xb(29'h1ABCDEF5); be[7] = xe(29'h1ABCDEF5, 0); bs[7] = 4'd2;
    send(xb(29'h1ABCDEF5), xe(29'h1ABCDEF5, 0), "R2 ext exact", 7);
    send(xb(29'h1ABCDEF4), xe(29'h1ABCDEF4, 0), "R2 ext low bit", -1);
    send(xb(29'h1ABCDEF5 ^ 29'h8000), xe(29'h1ABCDEF5, 0), "R2 ext id17_15", -1);
    send(sb(11'h6AF, 1), 0, "R2 ide differs", -1);

    bb[9] = sb(11'h055, 1); bs[9] = 4'd2;
    send(sb(11'h055, 0), 0, "R9 unmasked rtr", -1);
    bb[10] = xb(29'h0A5A5A5); be[10] = xe(29'h0A5A5A5, 1); bs[10] = 4'd2;
    send(xb(29'h0A5A5A5), xe(29'h0A5A5A5, 0), "R9 unmasked xrtr", -1);
    gmb = 16'h0010; gme = 16'h0001;
    send(sb(11'h055, 0), 0, "R9 std reply", 9);
    send(xb(29'h0A5A5A5), xe(29'h0A5A5A5, 0), "R9 ext reply", 10);
    gmb = 0; gme = 0;

    bb[14] = sb(11'h000, 0); bs[14] = 4'd2;
    send(sb(11'h000, 0), 0, "R4 last exact", 14);
    send(sb(11'h001, 0), 0, "R4 last basic mask zero", -1);
    bmb = 16'hFFFF; bme = 16'hFFFF;
    send(xb(29'h1234567), xe(29'h1234567, 1), "R4 catch-all", 14);
    send(sb(11'h123, 0), 0, "R6 regular over catch-all", 5);
    bmb = 0; bme = 0; gmb = 16'hFFFF; gme = 16'hFFFF;
    send(sb(11'h001, 0), 0, "R4 global not on last", 5);
    gmb = 0; gme = 0;

    for (int k = 0; k < 3000; k++) sweep_one();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule